// File: doc/BRIEF.md
# I2C Bus Clock Divider with Programmable Data Strobes

This block derives the serial clock of an I2C master from the core clock and tells the bit engine when to act on the data line. A divider value sets the period of the serial clock. The low and high phases each last half of that period, counted in core clocks. A packed delay word holds two offsets. The first sets how many core clocks into each low phase the engine drives its next data bit. The second sets how many core clocks into each high phase it samples the incoming bit.

The block is used with the enable input. While enable is low, the serial clock rests high and neither strobe fires. Once enable is raised, the clock stays high for one half period and then begins to toggle. Divider and delay values are captured only while the block is idle or at the first cycle of a low phase. A change made while the clock is running therefore never shortens the current phase.

Top module: `i2c_scl_timer`

## Requirements
- R1: During reset and while enable is low, scl_o is 1 and launch_stb and sample_stb are 0.
- R2: After enable is first seen high, scl_o stays 1 for H core clocks, then alternates H cycles at 0 and H cycles at 1, where H is the divider with bit 0 cleared, divided by two.
- R3: Bit 0 of the divider has no effect: an odd divider gives the same waveform as the even value one below it.
- R4: A divider of 0 or 1 behaves as a divider of 2 (H = 1).
- R5: launch_stb is high for exactly one core clock in each low phase, at position min(max(F,1),H), where the first low cycle is position 1 and F is the fall offset.
- R6: sample_stb is high for exactly one core clock in each high phase that follows a low phase, at position min(max(R,1),H) counted the same way, where R is the rise offset; it never fires in the high phase that follows enable.
- R7: An offset larger than H is clamped to H, so its strobe falls on the last cycle of the phase.
- R8: delay_cfg carries the fall offset F in bits 31:16 and the rise offset R in bits 15:0.
- R9: Divider and offset inputs are captured at the cycle enable is first seen high and at the first cycle of each low phase; changes at any other time do not alter the phase in progress or the high phase after it.
- R10: One cycle after enable is sampled low, scl_o is 1 with no strobes, and a later enable starts again with the H-cycle high lead-in.
- R11: launch_stb is only ever high while scl_o is 0, and sample_stb is only ever high while scl_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the serial clock while high |
| divider | input | 16 | Serial clock period in core clocks; bit 0 ignored |
| delay_cfg | input | 32 | Fall offset in 31:16, rise offset in 15:0 |
| scl_o | output | 1 | Serial clock level |
| launch_stb | output | 1 | One-cycle pulse: drive next data bit |
| sample_stb | output | 1 | One-cycle pulse: sample incoming data bit |

## Verification
The checker watches every cycle for the properties of strobe placement that hold regardless of settings. Each strobe stays inside its own clock level and lasts one cycle. Exactly one launch pulse occurs per completed low phase. No sample pulse appears in the lead-in. The outputs fall quiet after enable drops. The exact phase lengths, strobe positions, the effect of an odd or tiny divider, offset clamping, the field order of the delay word, and the cycle at which new settings take hold depend on the programmed values. Only the bench's scenarios show those, by comparing each cycle with a waveform computed from H, F and R.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

    // Phase of the serial clock generator
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // disabled, clock resting high
        PH_LEAD = 2'd1,   // first high half period after enable
        PH_LOW  = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

endpackage

// File: rtl/scl_delay_clamp.sv
// Limits one edge offset to the range 1..half.
module scl_delay_clamp #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] half,
    output logic [W-1:0] pos
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        if (raw == '0)
            pos = ONE;
        else if (raw > half)
            pos = half;
        else
            pos = raw;
    end
endmodule

// File: rtl/scl_cfg_calc.sv
// Turns raw divider and offsets into a half period and two strobe positions.
module scl_cfg_calc #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] divider,
    input  logic [W-1:0] fall_raw,
    input  logic [W-1:0] rise_raw,
    output logic [W-1:0] half,
    output logic [W-1:0] fall_pos,
    output logic [W-1:0] rise_pos
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
    localparam int unsigned  NUM_EDGES = 2;

    logic [W-1:0] half_raw;
    logic [W-1:0] raw_arr [NUM_EDGES];
    logic [W-1:0] pos_arr [NUM_EDGES];

    // bit 0 of the divider is dropped; a zero half period is raised to one
    assign half_raw = {1'b0, divider[W-1:1]};
    assign half     = (half_raw == '0) ? ONE : half_raw;

    assign raw_arr[0] = fall_raw;
    assign raw_arr[1] = rise_raw;

    for (genvar g = 0; g < NUM_EDGES; g++) begin : g_clamp
        scl_delay_clamp #(.W(W)) u_clamp (
            .raw  (raw_arr[g]),
            .half (half),
            .pos  (pos_arr[g])
        );
    end

    assign fall_pos = pos_arr[0];
    assign rise_pos = pos_arr[1];
endmodule

// File: rtl/scl_phase_gen.sv
// Phase sequencer: counts core clocks within each half period.
module scl_phase_gen
    import i2c_scl_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [W-1:0] half_in,
    input  logic [W-1:0] fall_in,
    input  logic [W-1:0] rise_in,
    output logic         scl_o,
    output logic         launch_stb,
    output logic         sample_stb
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        scl_phase_e   phase;
        logic [W-1:0] cnt;
        logic [W-1:0] half;
        logic [W-1:0] fall;
        logic [W-1:0] rise;
    } gen_state_t;

    gen_state_t st_q, st_d;
    logic       last_d;

    always_comb begin
        st_d   = st_q;
        last_d = (st_q.cnt == st_q.half - ONE);
        if (!enable) begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
            st_d.half  = half_in;
            st_d.fall  = fall_in;
            st_d.rise  = rise_in;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    st_d.phase = PH_LEAD;
                    st_d.cnt   = '0;
                    st_d.half  = half_in;
                    st_d.fall  = fall_in;
                    st_d.rise  = rise_in;
                end
                PH_LEAD, PH_HIGH: begin
                    if (last_d) begin
                        // new settings only at the start of a low phase
                        st_d.phase = PH_LOW;
                        st_d.cnt   = '0;
                        st_d.half  = half_in;
                        st_d.fall  = fall_in;
                        st_d.rise  = rise_in;
                    end else begin
                        st_d.cnt = st_q.cnt + ONE;
                    end
                end
                PH_LOW: begin
                    if (last_d) begin
                        st_d.phase = PH_HIGH;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + ONE;
                    end
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
            st_q.half  <= ONE;
            st_q.fall  <= ONE;
            st_q.rise  <= ONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_o      = (st_q.phase != PH_LOW);
    assign launch_stb = (st_q.phase == PH_LOW)  && (st_q.cnt == st_q.fall - ONE);
    assign sample_stb = (st_q.phase == PH_HIGH) && (st_q.cnt == st_q.rise - ONE);
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [CNT_W-1:0]   divider,
    input  logic [2*CNT_W-1:0] delay_cfg,
    output logic               scl_o,
    output logic               launch_stb,
    output logic               sample_stb
);
    localparam int unsigned DW = 2 * CNT_W;

    logic [CNT_W-1:0] half_w, fall_w, rise_w;

    scl_cfg_calc #(.W(CNT_W)) u_cfg (
        .divider  (divider),
        .fall_raw (delay_cfg[DW-1:CNT_W]),
        .rise_raw (delay_cfg[CNT_W-1:0]),
        .half     (half_w),
        .fall_pos (fall_w),
        .rise_pos (rise_w)
    );

    scl_phase_gen #(.W(CNT_W)) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .half_in    (half_w),
        .fall_in    (fall_w),
        .rise_in    (rise_w),
        .scl_o      (scl_o),
        .launch_stb (launch_stb),
        .sample_stb (sample_stb)
    );
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_o,
    input logic launch_stb,
    input logic sample_stb
);
    logic       seen_q;
    logic       scl_prev_q;
    logic       fell_q;
    logic [1:0] launches_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            scl_prev_q <= 1'b1;
            fell_q     <= 1'b0;
            launches_q <= 2'd0;
        end else begin
            seen_q     <= 1'b1;
            scl_prev_q <= scl_o;
            if (!enable)
                fell_q <= 1'b0;
            else if (scl_prev_q && !scl_o)
                fell_q <= 1'b1;
            if (scl_prev_q && !scl_o)
                launches_q <= {1'b0, launch_stb};
            else if (launch_stb && launches_q != 2'd3)
                launches_q <= launches_q + 2'd1;
        end
    end

    assert_launch_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        launch_stb |-> !scl_o);
    assert_sample_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> scl_o);
    assert_quiet_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(enable)) |-> (scl_o && !launch_stb && !sample_stb));
    assert_launch_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !scl_prev_q && scl_o && $past(enable)) |-> (launches_q == 2'd1));
    assert_launch_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        launch_stb |=> !launch_stb);
    assert_sample_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);
    assert_no_lead_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> fell_q);
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .scl_o      (scl_o),
    .launch_stb (launch_stb),
    .sample_stb (sample_stb)
);

// File: tb/i2c_scl_timer_bench.sv
module i2c_scl_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] divider = 16'd0;
    logic [31:0] delay_cfg = 32'd0;
    logic        scl_o, launch_stb, sample_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    i2c_scl_timer u_i2c_scl_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .divider    (divider),
        .delay_cfg  (delay_cfg),
        .scl_o      (scl_o),
        .launch_stb (launch_stb),
        .sample_stb (sample_stb)
    );

    task automatic chk(string req, int k, logic [2:0] got, logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: {scl,launch,sample} got %b expected %b",
                     req, k, got, exp);
        end
    endtask

    // Expected outputs k cycles after enable is taken. Before kb: lead-in
    // then low/high with (h1,f1,r1); from kb: a fresh low phase with (h2,f2,r2).
    function automatic logic [2:0] expect_at(int k, int h1, int f1, int r1,
                                             int kb, int h2, int f2, int r2);
        int p, pos;
        if (k < kb) begin
            p   = k / h1;
            pos = k % h1 + 1;
            if (p == 0)     return 3'b100;
            if (p % 2 == 1) return {1'b0, pos == f1, 1'b0};
            return {1'b1, 1'b0, pos == r1};
        end
        p   = (k - kb) / h2;
        pos = (k - kb) % h2 + 1;
        if (p % 2 == 0) return {1'b0, pos == f2, 1'b0};
        return {1'b1, 1'b0, pos == r2};
    endfunction

    task automatic idle_check(string req, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, i, {scl_o, launch_stb, sample_stb}, 3'b100);
        end
    endtask

    // Runs n cycles; at cycle kc the inputs switch to (ndiv, ndly).
    task automatic run_case(string req, logic [15:0] div, logic [31:0] dly,
                            int h1, int f1, int r1, int n, int kc,
                            logic [15:0] ndiv, logic [31:0] ndly,
                            int kb, int h2, int f2, int r2);
        @(negedge clk);
        divider   = div;
        delay_cfg = dly;
        enable    = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(req, k, {scl_o, launch_stb, sample_stb},
                expect_at(k, h1, f1, r1, kb, h2, f2, r2));
            if (k == kc) begin
                divider   = ndiv;
                delay_cfg = ndly;
            end
        end
        enable = 1'b0;
        idle_check("R10", 3);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", 0, {scl_o, launch_stb, sample_stb}, 3'b100);
        rst_n = 1'b1;
        idle_check("R1", 4);
    endtask

    task automatic t_basic;   // R2 R5 R6 R8: H=4, fall 1, rise 2
        run_case("R2/R5/R6/R8", 16'd8, {16'd1, 16'd2}, 4, 1, 2, 40,
                 -1, 16'd0, 32'd0, 1 << 30, 1, 1, 1);
    endtask

    task automatic t_odd;     // R3: 9 acts as 8
        run_case("R3", 16'd9, {16'd3, 16'd4}, 4, 3, 4, 40,
                 -1, 16'd0, 32'd0, 1 << 30, 1, 1, 1);
    endtask

    task automatic t_tiny;    // R4: 0 and 1 act as 2, offsets fold to 1
        run_case("R4", 16'd0, {16'd0, 16'd5}, 1, 1, 1, 12,
                 -1, 16'd0, 32'd0, 1 << 30, 1, 1, 1);
        run_case("R4", 16'd1, {16'd2, 16'd0}, 1, 1, 1, 12,
                 -1, 16'd0, 32'd0, 1 << 30, 1, 1, 1);
    endtask

    task automatic t_clamp;   // R7: H=5, both offsets oversize
        run_case("R7", 16'd10, {16'd100, 16'hFFFF}, 5, 5, 5, 50,
                 -1, 16'd0, 32'd0, 1 << 30, 1, 1, 1);
    endtask

    task automatic t_change_high;  // R9: change in 2nd high phase, used at k=12
        run_case("R9", 16'd8, {16'd1, 16'd2}, 4, 1, 2, 30,
                 9, 16'd4, {16'd2, 16'd1}, 12, 2, 2, 1);
    endtask

    task automatic t_change_low;   // R9: change in low phase, high unaffected
        run_case("R9", 16'd8, {16'd1, 16'd2}, 4, 1, 2, 48,
                 5, 16'd12, {16'd4, 16'd6}, 12, 6, 4, 6);
    endtask

    task automatic t_disable;      // R10: drop enable mid low phase, restart
        run_case("R10", 16'd8, {16'd3, 16'd2}, 4, 3, 2, 6,
                 -1, 16'd0, 32'd0, 1 << 30, 1, 1, 1);
        run_case("R10", 16'd6, {16'd2, 16'd3}, 3, 2, 3, 20,
                 -1, 16'd0, 32'd0, 1 << 30, 1, 1, 1);
    endtask

    task automatic t_big;          // R2 R3: largest half period
        run_case("R2/R3", 16'hFFFF, {16'd2, 16'd3}, 32767, 2, 3, 32767 + 8,
                 -1, 16'd0, 32'd0, 1 << 30, 1, 1, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_basic();
        t_odd();
        t_tiny();
        t_clamp();
        t_change_high();
        t_change_low();
        t_disable();
        t_big();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule